// File: doc/BRIEF.md
# Converter Power Sequencer

This block sequences an audio converter from its reset condition up to audio output and back down again. It watches the external reset line, a power-on-reset request, a flag for each of the three clocks (master, frame and bit) and the two flags that the clock-ratio detector raises: ratio valid and ratio changed. From these it steps through six operating states. In each state it drives the enables for the charge pump, the digital filters and modulator, the voltage reference and the output amplifiers. It also drives the output pull-downs and the mute.

A millisecond tick paces the power-up phase. The block waits a set number of ticks for the analog parts to settle before it unmutes. A separate, larger tick limit bounds that phase, and if the limit passes first an error flag is raised and the outputs stay muted. A change of ratio during playback mutes the output without powering anything down. Losing the master clock drops back to the power-down state. The current state is exposed on a 3-bit status port for test.

Top module: `conv_pwr_seq`

## Requirements
- R1: While `ext_rst_n` is low (asynchronously) or `por_req` is high (at the next clock edge), the state is reset (code 0). In that state the pull-downs are on, the mute is on and every enable is off.
- R2: When reset is released the block moves to power-down (code 1) at the next edge. It stays there, with the same outputs as reset, until `mclk_ok` is high.
- R3: With `mclk_ok` high, power-down moves to initialization (code 2). This state enables only the charge pump and keeps the pull-downs and mute on. It leaves only when `lrck_ok`, `sclk_ok` and `ratio_valid` are all high.
- R4: The power-up state (code 3) enables the charge pump, filters and modulator, reference and amplifiers, and turns the pull-downs off. The mute stays on.
- R5: Power-up moves to normal operation (code 4) on the first edge at which SETTLE_TICKS ticks have been counted in power-up, both serial clocks are present and the ratio is valid. The mute is off only in normal operation.
- R6: `ratio_chg` high in normal operation moves the block to the mute state (code 5), with all enables held and the mute on. It returns to normal operation when `ratio_valid` is high and `ratio_chg` is low.
- R7: A low `mclk_ok` in any state from initialization to mute moves the block to power-down at the next edge.
- R8: If LIMIT_TICKS ticks pass in power-up without completion, `pwrup_err` rises one edge later. The block then stays in power-up, muted, even if the ratio becomes valid. The flag clears when power-up is left.
- R9: With all clocks and the ratio already valid, normal operation is reached 3 + SETTLE_TICKS + 1 clock edges after reset release. With the defaults this is well under 50 ticks.
- R10: `deemph_en` is high only when `deemph_req` and `single_speed` are both high and the filters are enabled (codes 3, 4, 5).
- R11: The status port `state_o` carries the state codes listed in R1 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| por_req | input | 1 | Internal power-on-reset request, active high |
| mclk_ok | input | 1 | Master clock present |
| lrck_ok | input | 1 | Frame clock present |
| sclk_ok | input | 1 | Bit clock present |
| ratio_valid | input | 1 | Detector reports a supported clock ratio |
| ratio_chg | input | 1 | Detector reports a ratio change |
| ms_tick | input | 1 | Millisecond tick, one-cycle pulse |
| single_speed | input | 1 | Single-speed sample-rate range active |
| deemph_req | input | 1 | De-emphasis requested |
| cp_en | output | 1 | Charge pump enable |
| core_en | output | 1 | Filters and modulator enable |
| ref_en | output | 1 | Voltage reference enable |
| amp_en | output | 1 | Output amplifier enable |
| pulldown_en | output | 1 | Output pull-downs engaged |
| mute | output | 1 | Output muted |
| deemph_en | output | 1 | De-emphasis filter enable |
| pwrup_err | output | 1 | Power-up time limit exceeded |
| state_o | output | 3 | Current state code |

## Verification
The block's outputs are decoded straight from the state register, so any wrong state shows on `state_o` and on the enable pattern in the same cycle it is entered. A missed or extra transition therefore appears one edge after the stimulus that should or should not have caused it. The corner cases that matter are timing ones. These are the edge at which the settle count completes, the one-edge lag of the error flag behind the tick limit, and the asynchronous reset acting between edges. Each of them is checked at the exact cycle it is due.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   typedef enum logic [2:0] {
      ST_RESET = 3'd0,
      ST_PDOWN = 3'd1,
      ST_INIT  = 3'd2,
      ST_PWRUP = 3'd3,
      ST_RUN   = 3'd4,
      ST_MUTE  = 3'd5
   } cseq_state_e;

   typedef struct packed {
      logic cpump;
      logic dsp;
      logic vref;
      logic amp;
      logic pdn;
      logic mute;
   } cseq_ctl_t;

endpackage

// File: rtl/cseq_timer.sv
module cseq_timer #(
   parameter int SETTLE_TICKS = 4,
   parameter int LIMIT_TICKS  = 50,
   parameter bit TICK_EDGE    = 1'b0,
   localparam int CNT_W       = $clog2(LIMIT_TICKS + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic ms_tick,
   input  logic count_en,
   output logic settled,
   output logic expired
);

   localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_TICKS);
   localparam logic [CNT_W-1:0] LIMIT_C  = CNT_W'(LIMIT_TICKS);

   logic             tick_p;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (TICK_EDGE) begin : g_edge
         logic tick_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) tick_q <= 1'b0;
            else         tick_q <= ms_tick;
         end
         assign tick_p = ms_tick & ~tick_q;
      end else begin : g_pulse
         assign tick_p = ms_tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                        cnt_q <= '0;
      else if (!count_en)                 cnt_q <= '0;
      else if (tick_p && cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
   end

   assign settled = (cnt_q >= SETTLE_C);
   assign expired = (cnt_q >= LIMIT_C);

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
   import cseq_pkg::*;
(
   input  logic        clk,
   input  logic        arst_n,
   input  logic        por_req,
   input  logic        mclk_ok,
   input  logic        lrck_ok,
   input  logic        sclk_ok,
   input  logic        ratio_valid,
   input  logic        ratio_chg,
   input  logic        settled,
   input  logic        expired,
   output cseq_state_e state,
   output logic        err
);

   cseq_state_e state_d;
   logic        err_d;
   logic        clocks_ok;
   logic        pwrup_done;

   assign clocks_ok  = lrck_ok & sclk_ok;
   assign pwrup_done = ~err & settled & clocks_ok & ratio_valid;

   always_comb begin
      state_d = state;
      if (por_req) begin
         state_d = ST_RESET;
      end else begin
         case (state)
            ST_RESET: state_d = ST_PDOWN;
            ST_PDOWN: if (mclk_ok) state_d = ST_INIT;
            ST_INIT: begin
               if (!mclk_ok)                      state_d = ST_PDOWN;
               else if (clocks_ok && ratio_valid) state_d = ST_PWRUP;
            end
            ST_PWRUP: begin
               if (!mclk_ok)        state_d = ST_PDOWN;
               else if (pwrup_done) state_d = ST_RUN;
            end
            ST_RUN: begin
               if (!mclk_ok)       state_d = ST_PDOWN;
               else if (ratio_chg) state_d = ST_MUTE;
            end
            ST_MUTE: begin
               if (!mclk_ok)                       state_d = ST_PDOWN;
               else if (ratio_valid && !ratio_chg) state_d = ST_RUN;
            end
            default: state_d = ST_RESET;
         endcase
      end
   end

   always_comb begin
      err_d = 1'b0;
      if (state_d == ST_PWRUP)
         err_d = err | ((state == ST_PWRUP) & expired & ~pwrup_done);
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= ST_RESET;
         err   <= 1'b0;
      end else begin
         state <= state_d;
         err   <= err_d;
      end
   end

endmodule

// File: rtl/cseq_outdec.sv
module cseq_outdec
   import cseq_pkg::*;
(
   input  cseq_state_e state,
   input  logic        single_speed,
   input  logic        deemph_req,
   output cseq_ctl_t   ctl,
   output logic        deemph_en
);

   always_comb begin
      ctl = '{cpump: 1'b0, dsp: 1'b0, vref: 1'b0, amp: 1'b0, pdn: 1'b1, mute: 1'b1};
      case (state)
         ST_INIT:  ctl.cpump = 1'b1;
         ST_PWRUP, ST_MUTE: begin
            ctl = '{cpump: 1'b1, dsp: 1'b1, vref: 1'b1, amp: 1'b1, pdn: 1'b0, mute: 1'b1};
         end
         ST_RUN: begin
            ctl = '{cpump: 1'b1, dsp: 1'b1, vref: 1'b1, amp: 1'b1, pdn: 1'b0, mute: 1'b0};
         end
         default: ;
      endcase
   end

   assign deemph_en = deemph_req & single_speed & ctl.dsp;

endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
   import cseq_pkg::*;
#(
   parameter int SETTLE_TICKS = 4,
   parameter int LIMIT_TICKS  = 50,
   parameter int BUDGET_MS    = 50,
   parameter bit TICK_EDGE    = 1'b0
) (
   input  logic       clk,
   input  logic       ext_rst_n,
   input  logic       por_req,
   input  logic       mclk_ok,
   input  logic       lrck_ok,
   input  logic       sclk_ok,
   input  logic       ratio_valid,
   input  logic       ratio_chg,
   input  logic       ms_tick,
   input  logic       single_speed,
   input  logic       deemph_req,
   output logic       cp_en,
   output logic       core_en,
   output logic       ref_en,
   output logic       amp_en,
   output logic       pulldown_en,
   output logic       mute,
   output logic       deemph_en,
   output logic       pwrup_err,
   output logic [2:0] state_o
);

   generate
      if (SETTLE_TICKS < 1) begin : g_bad_settle
         $error("SETTLE_TICKS must be at least 1");
      end
      if (LIMIT_TICKS <= SETTLE_TICKS) begin : g_bad_limit
         $error("LIMIT_TICKS must exceed SETTLE_TICKS");
      end
      if (SETTLE_TICKS + 1 >= BUDGET_MS) begin : g_bad_budget
         $error("settle time does not fit the start-up budget");
      end
   endgenerate

   cseq_state_e state;
   cseq_ctl_t   ctl;
   logic        settled;
   logic        expired;

   cseq_timer #(
      .SETTLE_TICKS (SETTLE_TICKS),
      .LIMIT_TICKS  (LIMIT_TICKS),
      .TICK_EDGE    (TICK_EDGE)
   ) u_timer (
      .clk      (clk),
      .arst_n   (ext_rst_n),
      .ms_tick  (ms_tick),
      .count_en (state == ST_PWRUP),
      .settled  (settled),
      .expired  (expired)
   );

   cseq_fsm u_fsm (
      .clk         (clk),
      .arst_n      (ext_rst_n),
      .por_req     (por_req),
      .mclk_ok     (mclk_ok),
      .lrck_ok     (lrck_ok),
      .sclk_ok     (sclk_ok),
      .ratio_valid (ratio_valid),
      .ratio_chg   (ratio_chg),
      .settled     (settled),
      .expired     (expired),
      .state       (state),
      .err         (pwrup_err)
   );

   cseq_outdec u_dec (
      .state        (state),
      .single_speed (single_speed),
      .deemph_req   (deemph_req),
      .ctl          (ctl),
      .deemph_en    (deemph_en)
   );

   assign cp_en       = ctl.cpump;
   assign core_en     = ctl.dsp;
   assign ref_en      = ctl.vref;
   assign amp_en      = ctl.amp;
   assign pulldown_en = ctl.pdn;
   assign mute        = ctl.mute;
   assign state_o     = state;

endmodule

// File: rtl/conv_pwr_seq_chk.sv
module conv_pwr_seq_chk
   import cseq_pkg::*;
(
   input logic       clk,
   input logic       ext_rst_n,
   input logic       por_req,
   input logic       mclk_ok,
   input logic       ratio_valid,
   input logic       ratio_chg,
   input logic       single_speed,
   input logic       pulldown_en,
   input logic       amp_en,
   input logic       deemph_en,
   input logic       pwrup_err,
   input logic [2:0] state_o
);

   AST_POR_TO_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
      por_req |=> state_o == ST_RESET); // R1

   AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (state_o == ST_PDOWN && !mclk_ok && !por_req) |=> state_o == ST_PDOWN); // R2

   AST_PULLDOWN_AMP_EXCL: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !(pulldown_en && amp_en)); // R4

   AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (state_o == ST_RUN && $past(state_o) != ST_RUN) |->
         ($past(state_o) == ST_PWRUP || $past(state_o) == ST_MUTE)); // R5

   AST_CHG_TO_MUTE: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (state_o == ST_RUN && ratio_chg && mclk_ok && !por_req) |=> state_o == ST_MUTE); // R6

   AST_MUTE_RETURN: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (state_o == ST_MUTE && ratio_valid && !ratio_chg && mclk_ok && !por_req)
         |=> state_o == ST_RUN); // R6

   AST_MCLK_LOSS: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (state_o >= ST_INIT && state_o <= ST_MUTE && !mclk_ok && !por_req)
         |=> state_o == ST_PDOWN); // R7

   AST_ERR_IN_PWRUP: assert property (@(posedge clk) disable iff (!ext_rst_n)
      pwrup_err |-> state_o == ST_PWRUP); // R8

   AST_DEEMPH_SINGLE: assert property (@(posedge clk) disable iff (!ext_rst_n)
      deemph_en |-> single_speed); // R10

   AST_STATE_CODE: assert property (@(posedge clk) disable iff (!ext_rst_n)
      state_o <= 3'd5); // R11

endmodule

bind conv_pwr_seq conv_pwr_seq_chk u_chk (.*);

// File: tb/conv_pwr_seq_bench.sv
module conv_pwr_seq_bench;
   import cseq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int LIMIT      = 50;
   localparam int NV         = 22;

   // bits 13:4 = ext_rst_n, por_req, mclk_ok, lrck_ok, sclk_ok, ratio_valid,
   //             ratio_chg, ms_tick, single_speed, deemph_req
   // bits 3:1  = expected state code, bit 0 = expected deemph_en
   localparam logic [13:0] VEC [NV] = '{
      14'b0000000000_000_0,
      14'b1100000000_000_0,
      14'b1000000000_001_0,
      14'b1001110000_001_0,
      14'b1010000000_010_0,
      14'b1011010000_010_0,
      14'b1011100000_010_0,
      14'b1011110000_011_0,
      14'b1011110100_011_0,
      14'b1011110100_011_0,
      14'b1011110100_011_0,
      14'b1011110100_011_0,
      14'b1011110000_100_0,
      14'b1011111000_101_0,
      14'b1011111000_101_0,
      14'b1011110000_100_0,
      14'b1011110011_100_1,
      14'b1011110001_100_0,
      14'b1001110000_001_0,
      14'b1011110000_010_0,
      14'b1011110000_011_0,
      14'b1111110011_000_0
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic ext_rst_n = 1'b0, por_req = 1'b0, mclk_ok = 1'b0, lrck_ok = 1'b0;
   logic sclk_ok = 1'b0, ratio_valid = 1'b0, ratio_chg = 1'b0, ms_tick = 1'b0;
   logic single_speed = 1'b0, deemph_req = 1'b0;
   logic cp_en, core_en, ref_en, amp_en, pulldown_en, mute, deemph_en, pwrup_err;
   logic [2:0] state_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   conv_pwr_seq #(.SETTLE_TICKS(SETTLE), .LIMIT_TICKS(LIMIT)) u_conv_pwr_seq (
      .clk(clk), .ext_rst_n(ext_rst_n), .por_req(por_req), .mclk_ok(mclk_ok),
      .lrck_ok(lrck_ok), .sclk_ok(sclk_ok), .ratio_valid(ratio_valid),
      .ratio_chg(ratio_chg), .ms_tick(ms_tick), .single_speed(single_speed),
      .deemph_req(deemph_req), .cp_en(cp_en), .core_en(core_en), .ref_en(ref_en),
      .amp_en(amp_en), .pulldown_en(pulldown_en), .mute(mute),
      .deemph_en(deemph_en), .pwrup_err(pwrup_err), .state_o(state_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // {cp, core, ref, amp, pulldown, mute} per state, from R1..R6
   function automatic logic [5:0] exp_ctl(input logic [2:0] st);
      case (st)
         3'd2:          return 6'b100011;
         3'd3, 3'd5:    return 6'b111101;
         3'd4:          return 6'b111100;
         default:       return 6'b000011;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] st);
      case (st)
         3'd0: return "R1/R11";
         3'd1: return "R2/R11";
         3'd2: return "R3/R11";
         3'd3: return "R4/R11";
         3'd4: return "R5/R11";
         default: return "R6/R11";
      endcase
   endfunction

   task automatic drive(input logic [9:0] v);
      {ext_rst_n, por_req, mclk_ok, lrck_ok, sclk_ok, ratio_valid,
       ratio_chg, ms_tick, single_speed, deemph_req} = v;
   endtask

   task automatic check_state(input logic [2:0] st);
      chk(tag(st), "state", int'(state_o), int'(st));
      chk(tag(st), "controls",
          int'({cp_en, core_en, ref_en, amp_en, pulldown_en, mute}), int'(exp_ctl(st)));
   endtask

   task automatic tick_edge();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (2) @(posedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][13:4]);
         tick_edge();
         check_state(VEC[i][3:1]);
         chk("R10", "deemph_en", int'(deemph_en), int'(VEC[i][0]));
      end

      // R9: start-up latency with clocks already valid
      @(negedge clk);
      drive(10'b0011110100);
      @(negedge clk);
      ext_rst_n = 1'b1;
      begin
         int cyc = 0;
         while (state_o != 3'd4 && cyc < 200) begin
            tick_edge();
            cyc++;
         end
         chk("R9", "edges to normal operation", cyc, 3 + SETTLE + 1);
         chk("R9", "inside 50 tick budget", int'(cyc < 50), 1);
      end

      // R1 / R7: asynchronous reset between edges
      @(negedge clk);
      #2 ext_rst_n = 1'b0;
      #1;
      chk("R1", "async reset state", int'(state_o), 0);
      chk("R1", "pulldown in reset", int'(pulldown_en), 1);

      // R8: power-up time limit
      ms_tick = 1'b0;
      @(negedge clk);
      ext_rst_n = 1'b1;
      repeat (3) tick_edge();
      chk("R4", "reached power-up", int'(state_o), 3);
      @(negedge clk);
      ratio_valid = 1'b0;
      ms_tick = 1'b1;
      repeat (LIMIT) @(posedge clk);
      #1;
      chk("R8", "no error at limit edge", int'(pwrup_err), 0);
      @(negedge clk);
      ms_tick = 1'b0;
      tick_edge();
      chk("R8", "error raised", int'(pwrup_err), 1);
      chk("R8", "mute held", int'(mute), 1);
      @(negedge clk);
      ratio_valid = 1'b1;
      ms_tick = 1'b1;
      repeat (5) tick_edge();
      chk("R8", "stays in power-up", int'(state_o), 3);
      chk("R8", "error sticky", int'(pwrup_err), 1);
      @(negedge clk);
      mclk_ok = 1'b0;
      tick_edge();
      chk("R7", "mclk loss to power-down", int'(state_o), 1);
      chk("R8", "error cleared", int'(pwrup_err), 0);

      // R6 / R7: mute state then master clock loss
      @(negedge clk);
      mclk_ok = 1'b1;
      begin
         int cyc = 0;
         while (state_o != 3'd4 && cyc < 200) begin
            tick_edge();
            cyc++;
         end
      end
      @(negedge clk);
      ratio_chg = 1'b1;
      tick_edge();
      chk("R6", "ratio change mutes", int'(state_o), 5);
      chk("R6", "amp held in mute", int'(amp_en), 1);
      @(negedge clk);
      mclk_ok = 1'b0;
      tick_edge();
      chk("R7", "mclk loss from mute", int'(state_o), 1);
      chk("R2", "mute in power-down", int'(mute), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule